// File: doc/BRIEF.md
# Block Register Transfer Sequencer with Abort Suppression

This block steps through a multi-register load or store. It takes a 16-bit register list, a base address, the base register's index, a direction flag, a before/after addressing flag and a write-back enable. It then issues one memory access per cycle. Registers go out in ascending index order, and the address rises by 4 bytes on each access. For a load, each returned word becomes a register-file write request in the same cycle as the access.

The block samples a data-abort input on every access. An abort does not stop the sequence: every listed register is still accessed. From the faulting access onward, however, no loaded value reaches the register file. The base register is protected in two ways. A load into the base is held back until the end of the instruction. If an abort occurred, that held value is dropped, and the computed write-back address is used when write-back is enabled. Register 15 is always the last one in the list, so an aborted load never changes it.

A single-word swap mode reads and then writes the base address. If either access aborts, no register write takes place. If the read aborts, the write access is never issued. The instruction ends with a one-cycle `done` pulse, and `aborted` is valid during that pulse. The abort record is sticky for the rest of the instruction and clears when the next one starts.

Top module: `blk_xfer_seq`

## Requirements
- R1: The first access address is base+4 (up, before), base (up, after), base-4n (down, before) or base-4n+4 (down, after), where n is the number of set bits in the list. Registers are accessed lowest index first, and `mem_reg` carries the index.
- R2: Exactly one access is issued per cycle, in consecutive cycles starting the cycle after `start` is accepted. Each address is 4 above the previous one.
- R3: For a load with no abort so far, each access to a register other than the base raises `rf_we` in the same cycle, with `rf_idx` set to that register and `rf_wdata` equal to `mem_rdata`.
- R4: No register write occurs in the access cycle where `mem_abort` is high or in any later access cycle of that instruction. The base is never written with loaded data, and register 15 is never written.
- R5: After an abort, the remaining listed registers are still accessed at their normal addresses.
- R6: In the `done` cycle of a non-empty transfer, the base register is written. For a load with the base in the list and no abort, it receives the loaded value. Otherwise, when write-back is enabled, it receives base+4n (up) or base-4n (down). Otherwise it is not written.
- R7: Swap mode (`is_swap`=1) reads the base address (`mem_we`=0) and then writes it (`mem_we`=1). Both accesses use the lowest listed register as `mem_reg`. An abort on the read suppresses the write access. In the `done` cycle, the read data is written to that register only if neither access aborted.
- R8: `done` is a one-cycle pulse in the cycle after the last access. `aborted` is high in that cycle exactly when some access of the instruction aborted, and the record clears at the next `start`. After reset, `busy`, `mem_req`, `rf_we` and `done` are low.
- R9: An empty list (not swap) raises `done` in the cycle after `start`, with no access, no register write and `aborted` low.
- R10: A store drives `mem_we`=1 and issues no register write, except the write-back in the `done` cycle.
- R11: `start` is ignored while `busy` is high. An instruction in progress is unaffected, and the block returns to idle after its `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (sampled when idle) |
| is_load | input | 1 | 1 = load, 0 = store |
| is_swap | input | 1 | Single-word swap mode |
| reg_list | input | 16 | Register list, bit i selects register i |
| base_idx | input | 4 | Index of the base register |
| base_val | input | 32 | Base address |
| inc_up | input | 1 | 1 = addresses rise from base, 0 = fall |
| pre_idx | input | 1 | 1 = step before first access |
| wb_en | input | 1 | Write computed base back at the end |
| mem_rdata | input | 32 | Read data, valid in the access cycle |
| mem_abort | input | 1 | Data abort for the current access |
| busy | output | 1 | Instruction in progress |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Access address |
| mem_reg | output | 4 | Register transferred by this access |
| rf_we | output | 1 | Register-file write request |
| rf_idx | output | 4 | Register written |
| rf_wdata | output | 32 | Data written |
| done | output | 1 | End-of-instruction pulse |
| aborted | output | 1 | Instruction saw an abort (with `done`) |

## Verification
The bench aims aborts at the first access, at a middle access and at the access that loads the base. It checks that every later access still goes out and that nothing reaches the register file. A design that stopped at the fault would drop accesses. A design that cleared suppression after one cycle would let register 15 or a later register change. The bench runs loads that include the base with and without an abort, which exposes a design that writes the base in place or that favours the wrong source at the end. Swap runs place the abort on the read and on the write, to catch a design that still issues the write access or commits the swap data. Further runs cover an empty list, all four addressing modes, and a `start` held high during a busy instruction.

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int STEP = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    is_load,
  input  logic                    is_swap,
  input  logic [NREG-1:0]         reg_list,
  input  logic [$clog2(NREG)-1:0] base_idx,
  input  logic [AW-1:0]           base_val,
  input  logic                    inc_up,
  input  logic                    pre_idx,
  input  logic                    wb_en,
  input  logic [DW-1:0]           mem_rdata,
  input  logic                    mem_abort,
  output logic                    busy,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [AW-1:0]           mem_addr,
  output logic [$clog2(NREG)-1:0] mem_reg,
  output logic                    rf_we,
  output logic [$clog2(NREG)-1:0] rf_idx,
  output logic [DW-1:0]           rf_wdata,
  output logic                    done,
  output logic                    aborted
);
  localparam int IW = $clog2(NREG);
  localparam int CW = $clog2(NREG + 1);

  typedef enum logic [2:0] {S_IDLE, S_XFER, S_FIN, S_SRD, S_SWR} st_t;

  function automatic logic [IW-1:0] lowest(input logic [NREG-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (v[i]) r = IW'(i);
    return r;
  endfunction

  function automatic logic [CW-1:0] popc(input logic [NREG-1:0] v);
    logic [CW-1:0] r;
    r = '0;
    for (int i = 0; i < NREG; i++)
      r = r + CW'(v[i]);
    return r;
  endfunction

  st_t            st;
  logic [NREG-1:0] left;
  logic [AW-1:0]  addr, wbv;
  logic [IW-1:0]  base_r, sreg;
  logic           load_r, swap_r, wb_r, ab_r, hit_r;
  logic [DW-1:0]  hold;

  logic [IW-1:0]  cur;
  logic           acc, ab_now, last;
  logic [AW-1:0]  span, first, wb_calc;
  logic [CW-1:0]  cnt;

  assign cur     = lowest(left);
  assign acc     = (st == S_XFER) || (st == S_SRD) || (st == S_SWR);
  assign ab_now  = ab_r | (acc & mem_abort);
  assign last    = (left & (left - 1'b1)) == '0;

  assign cnt     = popc(reg_list);
  assign span    = AW'(cnt) * AW'(STEP);
  assign first   = inc_up ? (pre_idx ? base_val + AW'(STEP) : base_val)
                          : (pre_idx ? base_val - span : base_val - span + AW'(STEP));
  assign wb_calc = inc_up ? base_val + span : base_val - span;

  assign busy     = st != S_IDLE;
  assign mem_req  = acc;
  assign mem_we   = ((st == S_XFER) && !load_r) || (st == S_SWR);
  assign mem_addr = addr;
  assign mem_reg  = swap_r ? sreg : cur;
  assign done     = st == S_FIN;
  assign aborted  = done & ab_r;

  always_comb begin
    rf_we    = 1'b0;
    rf_idx   = cur;
    rf_wdata = mem_rdata;
    if (st == S_XFER) begin
      rf_we = load_r && !ab_now && (cur != base_r);
    end else if (st == S_FIN) begin
      if (swap_r) begin
        rf_we    = !ab_r;
        rf_idx   = sreg;
        rf_wdata = hold;
      end else if (load_r && hit_r && !ab_r) begin
        rf_we    = 1'b1;
        rf_idx   = base_r;
        rf_wdata = hold;
      end else if (wb_r) begin
        rf_we    = 1'b1;
        rf_idx   = base_r;
        rf_wdata = DW'(wbv);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      left   <= '0;
      addr   <= '0;
      wbv    <= '0;
      base_r <= '0;
      sreg   <= '0;
      load_r <= 1'b0;
      swap_r <= 1'b0;
      wb_r   <= 1'b0;
      ab_r   <= 1'b0;
      hit_r  <= 1'b0;
      hold   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          ab_r   <= 1'b0;
          hit_r  <= 1'b0;
          load_r <= is_load;
          swap_r <= is_swap;
          base_r <= base_idx;
          left   <= reg_list;
          sreg   <= lowest(reg_list);
          wbv    <= wb_calc;
          wb_r   <= wb_en && (reg_list != '0) && !is_swap;
          addr   <= is_swap ? base_val : first;
          if (is_swap)              st <= S_SRD;
          else if (reg_list == '0)  st <= S_FIN;
          else                      st <= S_XFER;
        end
        S_XFER: begin
          ab_r <= ab_now;
          if (load_r && (cur == base_r) && !ab_now) begin
            hold  <= mem_rdata;
            hit_r <= 1'b1;
          end
          left <= left & ~(NREG'(1) << cur);
          addr <= addr + AW'(STEP);
          if (last) st <= S_FIN;
        end
        S_SRD: begin
          ab_r <= ab_now;
          hold <= mem_rdata;
          st   <= ab_now ? S_FIN : S_SWR;
        end
        S_SWR: begin
          ab_r <= ab_now;
          st   <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module blk_xfer_seq_chk #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            is_swap,
  input logic [NREG-1:0] reg_list,
  input logic            busy,
  input logic            mem_req,
  input logic            mem_we,
  input logic [AW-1:0]   mem_addr,
  input logic            mem_abort,
  input logic            rf_we,
  input logic            done,
  input logic            aborted
);
  logic ab_seen, swap_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_seen  <= 1'b0;
      swap_cur <= 1'b0;
    end else if (start && !busy) begin
      ab_seen  <= 1'b0;
      swap_cur <= is_swap;
    end else if (mem_req && mem_abort) begin
      ab_seen <= 1'b1;
    end
  end

  AST_NO_WRITE_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && (ab_seen || mem_abort)) |-> !rf_we); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req) && !swap_cur) |-> mem_addr == $past(mem_addr) + AW'(STEP)); // R2
  AST_SWAP_READ_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_abort && swap_cur) |=> !mem_req); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_ABORT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (aborted == ab_seen)); // R8
  AST_EMPTY_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !is_swap && reg_list == '0) |=> (done && !mem_req && !aborted)); // R9
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.NREG(NREG), .AW(AW), .STEP(STEP)) u_chk (.*);

// File: tb/blk_xfer_seq_bench.sv
`timescale 1ns/1ps
module blk_xfer_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, is_load = 1'b0, is_swap = 1'b0;
  logic [15:0] reg_list = '0;
  logic [3:0]  base_idx = '0;
  logic [31:0] base_val = '0;
  logic        inc_up = 1'b0, pre_idx = 1'b0, wb_en = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_abort = 1'b0;
  logic        busy, mem_req, mem_we, rf_we, done, aborted;
  logic [31:0] mem_addr, rf_wdata;
  logic [3:0]  mem_reg, rf_idx;

  int checks = 0, errors = 0, opn = 0;

  always #2.5 clk = ~clk;

  blk_xfer_seq u_blk_xfer_seq (.*);

  function automatic logic [77:0] pack(logic b, logic rq, logic we, logic [31:0] a, logic [3:0] r,
                                       logic wr, logic [3:0] wi, logic [31:0] wd, logic d, logic ab);
    return {b, rq, rq ? we : 1'b0, rq ? a : 32'h0, rq ? r : 4'h0,
            wr, wr ? wi : 4'h0, wr ? wd : 32'h0, d, ab};
  endfunction

  task automatic chk(string tag, logic [77:0] act, logic [77:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(string tag, bit ld, bit sw, logic [15:0] lst, logic [3:0] bidx,
                        logic [31:0] bval, bit up, bit pre, bit wb, int abort_at, bit poke);
    int q[$];
    int n;
    logic [31:0] span, addr0, wbval, hold, rd0;
    bit ab, hit;
    for (int i = 0; i < 16; i++) if (lst[i]) q.push_back(i);
    n = q.size();
    span = 32'(n * 4);
    addr0 = up ? (pre ? bval + 4 : bval) : (pre ? bval - span : bval - span + 4);
    wbval = up ? bval + span : bval - span;
    ab = 0; hit = 0; hold = '0; rd0 = '0;
    opn++;
    start = 1; is_load = ld; is_swap = sw; reg_list = lst; base_idx = bidx;
    base_val = bval; inc_up = up; pre_idx = pre; wb_en = wb;
    for (int c = 0; c < 40; c++) begin
      logic [77:0] e;
      logic [31:0] rd;
      bit fin;
      @(negedge clk);
      rd = 32'hC0DE_0000 ^ (32'(opn) << 8) ^ 32'(c);
      mem_rdata = rd;
      mem_abort = (c == abort_at);
      fin = 0;
      if (poke) begin
        start = 1; is_swap = 0; reg_list = 16'h0; base_val = 32'hDEAD_0000;
      end else start = 0;
      if (sw) begin
        if (c == 0) begin
          rd0 = rd; ab = (c == abort_at);
          e = pack(1, 1, 0, bval, 4'(n ? q[0] : 0), 0, 0, 0, 0, 0);
        end else if (c == 1 && !ab) begin
          ab = (c == abort_at);
          e = pack(1, 1, 1, bval, 4'(n ? q[0] : 0), 0, 0, 0, 0, 0);
        end else begin
          fin = 1;
          e = pack(1, 0, 0, 0, 0, !ab, 4'(n ? q[0] : 0), rd0, 1, ab);
        end
      end else if (c < n) begin
        bit wr;
        if (c == abort_at) ab = 1;
        wr = ld && !ab && q[c] != int'(bidx);
        if (ld && !ab && q[c] == int'(bidx)) begin hold = rd; hit = 1; end
        e = pack(1, 1, !ld, addr0 + 32'(c * 4), 4'(q[c]), wr, 4'(q[c]), rd, 0, 0);
      end else begin
        fin = 1;
        if (n == 0)              e = pack(1, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        else if (ld && hit && !ab) e = pack(1, 0, 0, 0, 0, 1, bidx, hold, 1, ab);
        else if (wb)             e = pack(1, 0, 0, 0, 0, 1, bidx, wbval, 1, ab);
        else                     e = pack(1, 0, 0, 0, 0, 0, 0, 0, 1, ab);
      end
      if (fin) start = 0;
      #0.5;
      chk(tag, pack(busy, mem_req, mem_we, mem_addr, mem_reg, rf_we, rf_idx, rf_wdata, done, aborted), e);
      if (fin) break;
    end
    @(negedge clk);
    mem_abort = 0;
    #0.5;
    chk({tag, " R11 idle after done"}, {busy, mem_req, done, rf_we}, 78'(4'b0000));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #0.5;
    chk("R8 reset state", {busy, mem_req, rf_we, done, aborted}, 78'(5'b0));
    rst_n = 1;
    @(negedge clk);
    run_op("R1 R3 R6 load up after wb",     1, 0, 16'h00F0, 4'd2, 32'h0000_1000, 1, 0, 1, -1, 0);
    run_op("R1 R6 load down before base",   1, 0, 16'h8421, 4'd5, 32'h0000_2000, 0, 1, 0, -1, 0);
    run_op("R4 R5 R6 load base abort",      1, 0, 16'h8421, 4'd5, 32'h0000_2000, 0, 0, 1,  1, 0);
    run_op("R8 clean after abort",          1, 0, 16'h0003, 4'd9, 32'h0000_3000, 1, 1, 0, -1, 0);
    run_op("R4 abort first with pc",        1, 0, 16'h800C, 4'd1, 32'h0000_4000, 1, 1, 0,  0, 0);
    run_op("R4 base loaded then abort",     1, 0, 16'h0116, 4'd2, 32'h0000_4400, 1, 0, 0,  2, 0);
    run_op("R2 R10 store all up before",    0, 0, 16'hFFFF, 4'd13, 32'h0000_5000, 1, 1, 1, -1, 0);
    run_op("R5 R10 store down after abort", 0, 0, 16'h0F0F, 4'd13, 32'h0000_6000, 0, 0, 1,  3, 0);
    run_op("R9 empty list",                 1, 0, 16'h0000, 4'd3, 32'h0000_7000, 1, 0, 1, -1, 0);
    run_op("R7 swap clean",                 1, 1, 16'h0040, 4'd3, 32'h0000_8000, 1, 0, 0, -1, 0);
    run_op("R7 swap read abort",            1, 1, 16'h0040, 4'd3, 32'h0000_8000, 1, 0, 0,  0, 0);
    run_op("R7 swap write abort",           1, 1, 16'h0040, 4'd3, 32'h0000_8000, 1, 0, 0,  1, 0);
    run_op("R11 start while busy",          1, 0, 16'h00A5, 4'd0, 32'h0000_9000, 1, 0, 1, -1, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule